// File: doc/BRIEF.md
# Execute-stage squash and redirect generator

This block sits at the tail of the execute stage of a multithreaded out-of-order core. Three kinds of resolved events can arrive in each cycle, each on its own input port and each tagged with a thread number: a branch that resolved differently from its prediction, a memory-ordering violation, and a load that memory refused. For every thread the block keeps only the oldest event of the cycle. It turns that event into a squash record for the commit stage: the squashing sequence number, the resume address pair, a mispredict flag, a taken flag, the address of the mispredicted branch, and a flag that says whether the squashing instruction itself is discarded.

Each cause uses its own resume point and its own rule for including the squashing instruction. An elaboration-time delay-slot option changes how a branch computes its taken flag and its resume pair. The record and a per-thread acknowledge for refused loads are registered and last exactly one cycle. Two counters total the winning mispredictions by predicted direction.

Top module: `exec_squash_gen`

## Requirements
- R1: A winning branch event gives a record with valid=1, seq equal to the branch's sequence number, mispc equal to the branch PC, mispred=1 and incl=0.
- R2: With DELAY_SLOT=0, a winning branch resumes at (npc, npc+INST_SZ), and taken=1 exactly when npc differs from pc+INST_SZ.
- R3: With DELAY_SLOT=1, a winning branch has taken=0 only when nnpc equals npc+INST_SZ and npc equals either pc+INST_SZ or pc+2*INST_SZ. In every other case taken=1.
- R4: With DELAY_SLOT=1, a winning branch with its squash-delay-slot input high resumes at (npc, nnpc). With that input low it resumes at (nnpc, nnpc+INST_SZ).
- R5: A winning memory-order event resumes at npc. Its next PC is npc+INST_SZ, or nnpc when DELAY_SLOT=1. It sets mispred=0, taken=0, incl=0 and mispc=0.
- R6: A winning blocked-load event resumes at its own pc. Its next PC is pc+INST_SZ, or npc when DELAY_SLOT=1. It sets incl=1, mispred=0, taken=0 and mispc=0, and it raises ld_ack for that thread in the same cycle as the record.
- R7: Among the events for one thread in a cycle, the one with the smallest unsigned sequence number wins. On equal numbers the branch beats the memory-order event, and the memory-order event beats the blocked load. Events for different threads do not interact.
- R8: Each winning branch increments cnt_wrong_taken when its predicted-taken input is 1, and cnt_wrong_nt otherwise. A branch that loses is not counted.
- R9: A record appears one clock after its event and lasts exactly one cycle. In a cycle with no winner for a thread, that thread's valid, flags and ld_ack are 0 and all of its fields are 0.
- R10: While reset is held, every output is 0, including both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_v | input | 1 | Branch mispredict event valid |
| br_tid | input | TID_W | Branch thread |
| br_seq | input | SEQ_W | Branch sequence number |
| br_pc | input | PC_W | Branch PC |
| br_npc | input | PC_W | Branch actual next PC |
| br_nnpc | input | PC_W | Branch actual next-next PC |
| br_pred_tk | input | 1 | Branch was predicted taken |
| br_sq_ds | input | 1 | Squash the delay slot (delay-slot mode only) |
| mo_v | input | 1 | Memory-order violation valid |
| mo_tid | input | TID_W | Violation thread |
| mo_seq | input | SEQ_W | Violating instruction sequence number |
| mo_npc | input | PC_W | Violator next PC |
| mo_nnpc | input | PC_W | Violator next-next PC |
| bl_v | input | 1 | Blocked load valid |
| bl_tid | input | TID_W | Blocked load thread |
| bl_seq | input | SEQ_W | Blocked load sequence number |
| bl_pc | input | PC_W | Blocked load PC |
| bl_npc | input | PC_W | Blocked load next PC |
| sq_valid | output | NT | Squash record valid, one bit per thread |
| sq_seq | output | NT*SEQ_W | Squashing sequence number per thread |
| sq_pc | output | NT*PC_W | Resume PC per thread |
| sq_npc | output | NT*PC_W | Resume next PC per thread |
| sq_mispc | output | NT*PC_W | Mispredicted branch PC per thread |
| sq_mispred | output | NT | Squash caused by a branch mispredict |
| sq_taken | output | NT | Resolved branch direction was taken |
| sq_incl | output | NT | Squashing instruction itself is squashed |
| ld_ack | output | NT | Blocked load handled acknowledge |
| cnt_wrong_taken | output | CNT_W | Mispredicts predicted taken |
| cnt_wrong_nt | output | CNT_W | Mispredicts predicted not taken |

## Verification
Directed vectors first cover each cause alone. They use branch address triples chosen so that the straight-line, skip-one and truly taken cases give different taken flags and resume pairs in the two delay-slot builds, and these builds run side by side. Next come cycles where all three causes hit one thread with a different one oldest each time, plus a cycle with equal sequence numbers. These show whether the age comparison and the tie order are right, and whether a losing branch stays out of the counters. A long random phase draws sequence numbers from a small range and mixes threads, so collisions, ties and independent threads occur often. Addresses near pc+INST_SZ and pc+2*INST_SZ are favoured so that both arms of the delay-slot taken rule are exercised.

// File: rtl/exec_squash_gen.sv
module exec_squash_gen #(
  parameter int NT         = 2,
  parameter int PC_W       = 32,
  parameter int SEQ_W      = 16,
  parameter int INST_SZ    = 4,
  parameter int CNT_W      = 16,
  parameter bit DELAY_SLOT = 1'b0,
  localparam int TID_W     = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  br_v,
  input  logic [TID_W-1:0]      br_tid,
  input  logic [SEQ_W-1:0]      br_seq,
  input  logic [PC_W-1:0]       br_pc,
  input  logic [PC_W-1:0]       br_npc,
  input  logic [PC_W-1:0]       br_nnpc,
  input  logic                  br_pred_tk,
  input  logic                  br_sq_ds,
  input  logic                  mo_v,
  input  logic [TID_W-1:0]      mo_tid,
  input  logic [SEQ_W-1:0]      mo_seq,
  input  logic [PC_W-1:0]       mo_npc,
  input  logic [PC_W-1:0]       mo_nnpc,
  input  logic                  bl_v,
  input  logic [TID_W-1:0]      bl_tid,
  input  logic [SEQ_W-1:0]      bl_seq,
  input  logic [PC_W-1:0]       bl_pc,
  input  logic [PC_W-1:0]       bl_npc,
  output logic [NT-1:0]         sq_valid,
  output logic [NT*SEQ_W-1:0]   sq_seq,
  output logic [NT*PC_W-1:0]    sq_pc,
  output logic [NT*PC_W-1:0]    sq_npc,
  output logic [NT*PC_W-1:0]    sq_mispc,
  output logic [NT-1:0]         sq_mispred,
  output logic [NT-1:0]         sq_taken,
  output logic [NT-1:0]         sq_incl,
  output logic [NT-1:0]         ld_ack,
  output logic [CNT_W-1:0]      cnt_wrong_taken,
  output logic [CNT_W-1:0]      cnt_wrong_nt
);
  localparam logic [PC_W-1:0] SZ  = PC_W'(INST_SZ);
  localparam logic [PC_W-1:0] SZ2 = PC_W'(2 * INST_SZ);

  logic br_mo_same, br_bl_same, mo_bl_same;
  logic win_br, win_mo, win_bl;
  assign br_mo_same = br_v && mo_v && (br_tid == mo_tid);
  assign br_bl_same = br_v && bl_v && (br_tid == bl_tid);
  assign mo_bl_same = mo_v && bl_v && (mo_tid == bl_tid);

  assign win_br = br_v && !(br_mo_same && (mo_seq <  br_seq)) && !(br_bl_same && (bl_seq <  br_seq));
  assign win_mo = mo_v && !(br_mo_same && (br_seq <= mo_seq)) && !(mo_bl_same && (bl_seq <  mo_seq));
  assign win_bl = bl_v && !(br_bl_same && (br_seq <= bl_seq)) && !(mo_bl_same && (mo_seq <= bl_seq));

  logic            br_tk;
  logic [PC_W-1:0] br_rpc, br_rnpc, mo_rnpc, bl_rnpc;
  assign br_tk   = DELAY_SLOT ? !((br_nnpc == br_npc + SZ) && ((br_npc == br_pc + SZ) || (br_npc == br_pc + SZ2)))
                              : (br_npc != br_pc + SZ);
  assign br_rpc  = DELAY_SLOT ? (br_sq_ds ? br_npc  : br_nnpc)      : br_npc;
  assign br_rnpc = DELAY_SLOT ? (br_sq_ds ? br_nnpc : br_nnpc + SZ) : br_npc + SZ;
  assign mo_rnpc = DELAY_SLOT ? mo_nnpc : mo_npc + SZ;
  assign bl_rnpc = DELAY_SLOT ? bl_npc  : bl_pc + SZ;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_wrong_taken <= '0;
      cnt_wrong_nt    <= '0;
    end else if (win_br) begin
      if (br_pred_tk) cnt_wrong_taken <= cnt_wrong_taken + 1'b1;
      else            cnt_wrong_nt    <= cnt_wrong_nt + 1'b1;
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic sel_br, sel_mo, sel_bl;
    assign sel_br = win_br && (br_tid == TID_W'(t));
    assign sel_mo = win_mo && (mo_tid == TID_W'(t));
    assign sel_bl = win_bl && (bl_tid == TID_W'(t));

    always_ff @(posedge clk) begin
      sq_valid[t]               <= 1'b0;
      sq_seq[t*SEQ_W +: SEQ_W]  <= '0;
      sq_pc[t*PC_W +: PC_W]     <= '0;
      sq_npc[t*PC_W +: PC_W]    <= '0;
      sq_mispc[t*PC_W +: PC_W]  <= '0;
      sq_mispred[t]             <= 1'b0;
      sq_taken[t]               <= 1'b0;
      sq_incl[t]                <= 1'b0;
      ld_ack[t]                 <= 1'b0;
      if (!rst) begin
        if (sel_br) begin
          sq_valid[t]              <= 1'b1;
          sq_seq[t*SEQ_W +: SEQ_W] <= br_seq;
          sq_pc[t*PC_W +: PC_W]    <= br_rpc;
          sq_npc[t*PC_W +: PC_W]   <= br_rnpc;
          sq_mispc[t*PC_W +: PC_W] <= br_pc;
          sq_mispred[t]            <= 1'b1;
          sq_taken[t]              <= br_tk;
        end else if (sel_mo) begin
          sq_valid[t]              <= 1'b1;
          sq_seq[t*SEQ_W +: SEQ_W] <= mo_seq;
          sq_pc[t*PC_W +: PC_W]    <= mo_npc;
          sq_npc[t*PC_W +: PC_W]   <= mo_rnpc;
        end else if (sel_bl) begin
          sq_valid[t]              <= 1'b1;
          sq_seq[t*SEQ_W +: SEQ_W] <= bl_seq;
          sq_pc[t*PC_W +: PC_W]    <= bl_pc;
          sq_npc[t*PC_W +: PC_W]   <= bl_rnpc;
          sq_incl[t]               <= 1'b1;
          ld_ack[t]                <= 1'b1;
        end
      end
    end

    assert_ack_record_R6: assert property (@(posedge clk) disable iff (rst)
      ld_ack[t] |-> (sq_valid[t] && sq_incl[t] && !sq_mispred[t]));
    assert_taken_is_branch_R1: assert property (@(posedge clk) disable iff (rst)
      sq_taken[t] |-> (sq_mispred[t] && !sq_incl[t]));
    assert_older_branch_blocks_load_R7: assert property (@(posedge clk) disable iff (rst)
      (bl_v && br_v && bl_tid == TID_W'(t) && br_tid == TID_W'(t) && br_seq < bl_seq) |=> !ld_ack[t]);
    assert_idle_clears_R9: assert property (@(posedge clk) disable iff (rst)
      !(br_v || mo_v || bl_v) |=> (!sq_valid[t] && !ld_ack[t]));
  end

  assert_count_on_mispred_R8: assert property (@(posedge clk) disable iff (rst)
    ((cnt_wrong_taken != $past(cnt_wrong_taken)) || (cnt_wrong_nt != $past(cnt_wrong_nt))) |-> (|sq_mispred));
  assert_single_count_R8: assert property (@(posedge clk) disable iff (rst)
    !((cnt_wrong_taken != $past(cnt_wrong_taken)) && (cnt_wrong_nt != $past(cnt_wrong_nt))));
endmodule

// File: tb/exec_squash_gen_tb_top.sv
module exec_squash_gen_tb_top;
  localparam int NT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        p_v   [3];
  logic        p_tid [3];
  logic [15:0] p_seq [3];
  logic [31:0] br_pc, br_npc, br_nnpc, mo_npc, mo_nnpc, bl_pc, bl_npc;
  logic        br_pred_tk, br_sq_ds;

  logic [NT-1:0]    o_v [2], o_mp [2], o_tk [2], o_in [2], o_ack [2];
  logic [NT*16-1:0] o_seq [2];
  logic [NT*32-1:0] o_pc [2], o_npc [2], o_mpc [2];
  logic [15:0]      o_ct [2], o_cn [2];

  exec_squash_gen #(.NT(NT), .DELAY_SLOT(1'b0)) dut_i (
    .clk, .rst,
    .br_v(p_v[0]), .br_tid(p_tid[0]), .br_seq(p_seq[0]), .br_pc, .br_npc, .br_nnpc, .br_pred_tk, .br_sq_ds,
    .mo_v(p_v[1]), .mo_tid(p_tid[1]), .mo_seq(p_seq[1]), .mo_npc, .mo_nnpc,
    .bl_v(p_v[2]), .bl_tid(p_tid[2]), .bl_seq(p_seq[2]), .bl_pc, .bl_npc,
    .sq_valid(o_v[0]), .sq_seq(o_seq[0]), .sq_pc(o_pc[0]), .sq_npc(o_npc[0]), .sq_mispc(o_mpc[0]),
    .sq_mispred(o_mp[0]), .sq_taken(o_tk[0]), .sq_incl(o_in[0]), .ld_ack(o_ack[0]),
    .cnt_wrong_taken(o_ct[0]), .cnt_wrong_nt(o_cn[0]));

  exec_squash_gen #(.NT(NT), .DELAY_SLOT(1'b1)) dut_ds_i (
    .clk, .rst,
    .br_v(p_v[0]), .br_tid(p_tid[0]), .br_seq(p_seq[0]), .br_pc, .br_npc, .br_nnpc, .br_pred_tk, .br_sq_ds,
    .mo_v(p_v[1]), .mo_tid(p_tid[1]), .mo_seq(p_seq[1]), .mo_npc, .mo_nnpc,
    .bl_v(p_v[2]), .bl_tid(p_tid[2]), .bl_seq(p_seq[2]), .bl_pc, .bl_npc,
    .sq_valid(o_v[1]), .sq_seq(o_seq[1]), .sq_pc(o_pc[1]), .sq_npc(o_npc[1]), .sq_mispc(o_mpc[1]),
    .sq_mispred(o_mp[1]), .sq_taken(o_tk[1]), .sq_incl(o_in[1]), .ld_ack(o_ack[1]),
    .cnt_wrong_taken(o_ct[1]), .cnt_wrong_nt(o_cn[1]));

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] e_v [2][NT], e_seq [2][NT], e_pc [2][NT], e_npc [2][NT], e_mpc [2][NT];
  logic [31:0] e_mp [2][NT], e_tk [2][NT], e_in [2][NT], e_ack [2][NT];
  string       tg_pc [2][NT], tg_tk [2][NT], tg_v [2][NT];
  int          e_ct = 0, e_cn = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    for (int d = 0; d < 2; d++) begin
      for (int t = 0; t < NT; t++) begin
        chk(tg_v[d][t], "valid",   32'(o_v[d][t]), e_v[d][t]);
        chk("R7", "seq",           32'(o_seq[d][t*16 +: 16]), e_seq[d][t]);
        chk(tg_pc[d][t], "pc",     o_pc[d][t*32 +: 32], e_pc[d][t]);
        chk(tg_pc[d][t], "npc",    o_npc[d][t*32 +: 32], e_npc[d][t]);
        chk("R1", "mispc",         o_mpc[d][t*32 +: 32], e_mpc[d][t]);
        chk("R1", "mispred",       32'(o_mp[d][t]), e_mp[d][t]);
        chk(tg_tk[d][t], "taken",  32'(o_tk[d][t]), e_tk[d][t]);
        chk(tg_pc[d][t], "incl",   32'(o_in[d][t]), e_in[d][t]);
        chk("R6", "ld_ack",        32'(o_ack[d][t]), e_ack[d][t]);
      end
      chk("R8", "cnt_wrong_taken", 32'(o_ct[d]), 32'(e_ct));
      chk("R8", "cnt_wrong_nt",    32'(o_cn[d]), 32'(e_cn));
    end
  endtask

  task automatic model();
    for (int d = 0; d < 2; d++) begin
      for (int t = 0; t < NT; t++) begin
        int best = -1;
        for (int p = 0; p < 3; p++)
          if (p_v[p] && int'(p_tid[p]) == t && (best < 0 || p_seq[p] < p_seq[best])) best = p;
        e_v[d][t] = 0; e_seq[d][t] = 0; e_pc[d][t] = 0; e_npc[d][t] = 0; e_mpc[d][t] = 0;
        e_mp[d][t] = 0; e_tk[d][t] = 0; e_in[d][t] = 0; e_ack[d][t] = 0;
        tg_pc[d][t] = "R9"; tg_tk[d][t] = "R9"; tg_v[d][t] = "R9";
        if (best >= 0) begin
          e_v[d][t] = 1; e_seq[d][t] = 32'(p_seq[best]); tg_v[d][t] = "R7";
          if (best == 0) begin
            e_mpc[d][t] = br_pc; e_mp[d][t] = 1;
            if (d == 0) begin
              e_tk[d][t] = 32'(br_npc != br_pc + 32'd4);
              e_pc[d][t] = br_npc; e_npc[d][t] = br_npc + 32'd4;
              tg_pc[d][t] = "R2"; tg_tk[d][t] = "R2";
            end else begin
              e_tk[d][t] = 32'(!((br_nnpc == br_npc + 32'd4) &&
                                 ((br_npc == br_pc + 32'd4) || (br_npc == br_pc + 32'd8))));
              if (br_sq_ds) begin e_pc[d][t] = br_npc;  e_npc[d][t] = br_nnpc; end
              else          begin e_pc[d][t] = br_nnpc; e_npc[d][t] = br_nnpc + 32'd4; end
              tg_pc[d][t] = "R4"; tg_tk[d][t] = "R3";
            end
            if (d == 0) begin
              if (br_pred_tk) e_ct++; else e_cn++;
            end
          end else if (best == 1) begin
            e_pc[d][t] = mo_npc; e_npc[d][t] = (d == 1) ? mo_nnpc : mo_npc + 32'd4;
            tg_pc[d][t] = "R5"; tg_tk[d][t] = "R5";
          end else begin
            e_pc[d][t] = bl_pc; e_npc[d][t] = (d == 1) ? bl_npc : bl_pc + 32'd4;
            e_in[d][t] = 1; e_ack[d][t] = 1;
            tg_pc[d][t] = "R6"; tg_tk[d][t] = "R6";
          end
        end
      end
    end
  endtask

  task automatic clear_in();
    for (int p = 0; p < 3; p++) begin p_v[p] = 0; p_tid[p] = 0; p_seq[p] = 0; end
    br_pc = 0; br_npc = 0; br_nnpc = 0; mo_npc = 0; mo_nnpc = 0; bl_pc = 0; bl_npc = 0;
    br_pred_tk = 0; br_sq_ds = 0;
  endtask

  task automatic apply();
    @(negedge clk);
    compare();
    p_v = n_v; p_tid = n_tid; p_seq = n_seq;
    br_pc = n_bpc; br_npc = n_bnpc; br_nnpc = n_bnnpc; mo_npc = n_mnpc; mo_nnpc = n_mnnpc;
    bl_pc = n_lpc; bl_npc = n_lnpc; br_pred_tk = n_ptk; br_sq_ds = n_sds;
    model();
  endtask

  logic        n_v [3], n_tid [3];
  logic [15:0] n_seq [3];
  logic [31:0] n_bpc, n_bnpc, n_bnnpc, n_mnpc, n_mnnpc, n_lpc, n_lnpc;
  logic        n_ptk, n_sds;

  task automatic idle_next();
    for (int p = 0; p < 3; p++) begin n_v[p] = 0; n_tid[p] = 0; n_seq[p] = 0; end
    n_bpc = 0; n_bnpc = 0; n_bnnpc = 0; n_mnpc = 0; n_mnnpc = 0; n_lpc = 0; n_lnpc = 0;
    n_ptk = 0; n_sds = 0;
  endtask

  task automatic set_br(logic tid, logic [15:0] s, logic [31:0] pc, logic [31:0] npc, logic [31:0] nnpc, logic ptk, logic sds);
    n_v[0] = 1; n_tid[0] = tid; n_seq[0] = s; n_bpc = pc; n_bnpc = npc; n_bnnpc = nnpc; n_ptk = ptk; n_sds = sds;
  endtask
  task automatic set_mo(logic tid, logic [15:0] s, logic [31:0] npc, logic [31:0] nnpc);
    n_v[1] = 1; n_tid[1] = tid; n_seq[1] = s; n_mnpc = npc; n_mnnpc = nnpc;
  endtask
  task automatic set_bl(logic tid, logic [15:0] s, logic [31:0] pc, logic [31:0] npc);
    n_v[2] = 1; n_tid[2] = tid; n_seq[2] = s; n_lpc = pc; n_lnpc = npc;
  endtask

  initial begin
    clear_in();
    idle_next();
    model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      chk("R10", "reset valid",  32'(o_v[d]), 0);
      chk("R10", "reset ack",    32'(o_ack[d]), 0);
      chk("R10", "reset pc",     o_pc[d][31:0], 0);
      chk("R10", "reset cnt_t",  32'(o_ct[d]), 0);
      chk("R10", "reset cnt_nt", 32'(o_cn[d]), 0);
    end
    rst = 1'b0;

    idle_next(); set_br(0, 16'd5, 32'h100, 32'h200, 32'h204, 0, 0); apply();
    idle_next(); set_br(1, 16'd6, 32'h100, 32'h104, 32'h108, 1, 1); apply();
    idle_next(); set_br(0, 16'd6, 32'h100, 32'h108, 32'h10c, 1, 0); apply();
    idle_next(); set_br(1, 16'd6, 32'h100, 32'h104, 32'h300, 0, 0); apply();
    idle_next(); set_mo(0, 16'd7, 32'h300, 32'h400); apply();
    idle_next(); set_bl(1, 16'd9, 32'h500, 32'h504); apply();
    idle_next(); apply();
    idle_next(); set_br(0, 16'd10, 32'h10, 32'h80, 32'h84, 1, 0);
                 set_mo(0, 16'd3, 32'h40, 32'h44); set_bl(0, 16'd8, 32'h60, 32'h64); apply();
    idle_next(); set_br(1, 16'd10, 32'h10, 32'h80, 32'h84, 1, 0);
                 set_mo(1, 16'd3, 32'h40, 32'h44); set_bl(1, 16'd2, 32'h60, 32'h64); apply();
    idle_next(); set_br(0, 16'd4, 32'h10, 32'h80, 32'h84, 0, 1);
                 set_mo(0, 16'd4, 32'h40, 32'h44); set_bl(0, 16'd4, 32'h60, 32'h64); apply();
    idle_next(); set_mo(1, 16'd4, 32'h40, 32'h48); set_bl(1, 16'd4, 32'h60, 32'h68); apply();
    idle_next(); set_br(0, 16'd20, 32'h10, 32'h14, 32'h18, 0, 1); set_bl(1, 16'd1, 32'h70, 32'h74); apply();
    idle_next(); apply();

    for (int i = 0; i < 3000; i++) begin
      idle_next();
      for (int p = 0; p < 3; p++) begin
        logic [31:0] pc, npc, nnpc;
        pc = {$urandom_range(0, 255), 2'b00};
        case ($urandom_range(0, 2))
          0: npc = pc + 32'd4;
          1: npc = pc + 32'd8;
          default: npc = {$urandom_range(0, 255), 2'b00};
        endcase
        nnpc = ($urandom_range(0, 1) == 0) ? npc + 32'd4 : {$urandom_range(0, 255), 2'b00};
        if ($urandom_range(0, 2) != 0) begin
          case (p)
            0: set_br(1'($urandom_range(0, 1)), 16'($urandom_range(0, 15)), pc, npc, nnpc,
                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            1: set_mo(1'($urandom_range(0, 1)), 16'($urandom_range(0, 15)), npc, nnpc);
            default: set_bl(1'($urandom_range(0, 1)), 16'($urandom_range(0, 15)), pc, npc);
          endcase
        end
      end
      apply();
    end
    idle_next(); apply();
    idle_next(); apply();

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule